// File: doc/BRIEF.md
# Rename Map Table with Carried Parity and Snapshots

This block holds the speculative mapping from each logical register to a physical register identifier. Each identifier carries one parity bit. The parity bit is produced once, outside the block, when the identifier enters circulation. After that the bit travels with the identifier and the table never recomputes it. Two source ports read a mapping in the same cycle they are asked. Only these source reads check the parity. A valid read with a bad parity bit makes the block request a flush back to the oldest in-flight instruction.

A destination port stores a newly allocated identifier together with the parity bit it arrived with. In the same cycle the port presents the mapping being replaced, so that identifier can be freed at retire. Four snapshot slots are used as a ring. Each slot copies the whole table, parity bits included, and no check is made when a snapshot is taken or restored. Restoring a slot discards every younger slot.

A small controller has two states:
- `ST_RUN` is normal renaming.
- `ST_FLUSH` means a parity error is pending. In this state destination writes and snapshot takes are blocked, and further errors are ignored.

The transition `T_DETECT` (`ST_RUN` to `ST_FLUSH`) fires on a parity error from any valid source read. The transition `T_RECOVER` (`ST_FLUSH` to `ST_RUN`) fires on the restore of a live snapshot slot.

Top module: `rmt_alias_table`

## Requirements
- R1: After reset, logical register i maps to identifier i. Its parity bit equals the XOR of the identifier bits, so the XOR of all 8 stored bits is 0.
- R2: Each source port returns the stored identifier and parity bit of its logical register in the same cycle, without modification.
- R3: A source read with its valid bit set, whose 8 bits XOR to 1, raises flush_req from the next cycle on. A source read whose valid bit is low is never checked, and good parity raises nothing.
- R4: flush_req stays high until a cycle that restores a live snapshot slot, and falls in the cycle after that one. Parity errors seen while flush_req is high change nothing.
- R5: An accepted destination write stores the given identifier and parity bit unchanged, with no check, and they are readable from the next cycle. old_pid/old_par show the current mapping of dst_lreg in the same cycle.
- R6: A source read of the register being written in the same cycle returns the previous mapping.
- R7: A destination write is dropped in any cycle where flush_req is high or snap_restore is asserted.
- R8: A take captures the table as it stood before any write in that cycle, parity bits included. Slots are handed out in ring order 0,1,2,3,0,… and the slot number appears on snap_take_slot. snap_take_ok answers in the same cycle.
- R9: A take is refused (snap_take_ok low) when four slots are live, when flush_req is high, or when snap_restore is asserted.
- R10: A release frees the oldest live slot. A release with no live slot, or in a cycle with snap_restore asserted, has no effect.
- R11: Restoring a live slot replaces the whole table from the next cycle and keeps that slot live. Younger slots are freed, so the next take reuses the slot after it. Restoring a slot that is not live has no effect.
- R12: A wrong parity bit held in a snapshot raises no flush when it is taken or restored. It is flagged only when a valid source read reaches it after restore.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_vld | input | 2 | Per-port request to rename a source (enables the check) |
| src_lreg | input | 2x5 | Logical register per source port |
| src_pid | output | 2x7 | Mapped identifier per source port |
| src_par | output | 2 | Carried parity bit per source port |
| dst_vld | input | 1 | Destination write request |
| dst_lreg | input | 5 | Logical register being renamed |
| dst_pid | input | 7 | Newly allocated identifier |
| dst_par | input | 1 | Parity bit arriving with dst_pid |
| old_pid | output | 7 | Identifier currently mapped to dst_lreg |
| old_par | output | 1 | Parity bit currently mapped to dst_lreg |
| snap_take | input | 1 | Request to capture a snapshot |
| snap_take_ok | output | 1 | Take accepted this cycle |
| snap_take_slot | output | 2 | Slot that the next accepted take fills |
| snap_release | input | 1 | Free the oldest live slot |
| snap_restore | input | 1 | Restore request |
| snap_restore_slot | input | 2 | Slot to restore |
| flush_req | output | 1 | Flush to the oldest instruction requested |

## Verification
Source mappings, the evicted mapping and snap_take_ok are combinational, so they are due in the cycle the request is driven. The bench drives inputs just after the falling edge and samples these outputs 1 ns later, before the rising edge commits anything. Table contents after a write or restore, and the rise or fall of flush_req, are due one rising edge later. The bench samples them at the next falling edge. Sweeps over all 32 logical registers with both ports compare every entry against a model table kept in the bench, which is updated only after the committing edge.

// File: rtl/rmt_pkg.sv
package rmt_pkg;

    // Configuration of the map table
    parameter int unsigned LREG_N = 32;   // logical registers
    parameter int unsigned PID_W  = 7;    // physical identifier width
    parameter int unsigned SNAP_N = 4;    // snapshot slots, power of two
    parameter int unsigned SRC_N  = 2;    // source rename ports

    localparam int unsigned LREG_W = $clog2(LREG_N);
    localparam int unsigned SNAP_W = $clog2(SNAP_N);
    localparam int unsigned CNT_W  = SNAP_W + 1;

    // One table entry: identifier plus the parity bit that travels with it
    typedef struct packed {
        logic [PID_W-1:0] pid;
        logic             par;
    } map_ent_t;

    typedef map_ent_t [LREG_N-1:0] map_img_t;

    typedef enum logic [0:0] {
        ST_RUN   = 1'b0,
        ST_FLUSH = 1'b1
    } ctrl_state_t;

    // Identity mapping used at reset, with even parity over the 8 bits
    function automatic map_ent_t home_entry(input int unsigned idx);
        map_ent_t e;
        e.pid = PID_W'(idx);
        e.par = ^e.pid;
        return e;
    endfunction

endpackage

// File: rtl/rmt_map_array.sv
module rmt_map_array
    import rmt_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [SRC_N-1:0][LREG_W-1:0]  rd_lreg,
    output map_ent_t [SRC_N-1:0]          rd_ent,
    input  logic                          wr_en,
    input  logic [LREG_W-1:0]             wr_lreg,
    input  map_ent_t                      wr_ent,
    output map_ent_t                      ev_ent,
    input  logic                          load_en,
    input  map_img_t                      load_img,
    output map_img_t                      cur_img
);

    map_img_t tab_q;

    // Whole-table load wins over a single-entry write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < LREG_N; i++) begin
                tab_q[i] <= home_entry(i);
            end
        end else if (load_en) begin
            tab_q <= load_img;
        end else if (wr_en) begin
            tab_q[wr_lreg] <= wr_ent;
        end
    end

    // Read ports see the state before this cycle's update
    for (genvar g = 0; g < SRC_N; g++) begin : g_rd
        assign rd_ent[g] = tab_q[rd_lreg[g]];
    end

    assign ev_ent  = tab_q[wr_lreg];
    assign cur_img = tab_q;

endmodule

// File: rtl/rmt_par_check.sv
module rmt_par_check
    import rmt_pkg::*;
(
    input  logic [SRC_N-1:0] vld,
    input  map_ent_t [SRC_N-1:0] ent,
    output logic             any_err
);

    logic [SRC_N-1:0] port_err;

    // Odd XOR over identifier and carried bit marks a corrupted mapping
    for (genvar g = 0; g < SRC_N; g++) begin : g_chk
        assign port_err[g] = vld[g] & (^ent[g]);
    end

    assign any_err = |port_err;

endmodule

// File: rtl/rmt_snap_store.sv
module rmt_snap_store
    import rmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              rel,
    input  logic              restore,
    input  logic [SNAP_W-1:0] restore_slot,
    input  map_img_t          cur_img,
    output logic              take_ok,
    output logic [SNAP_W-1:0] take_slot,
    output logic              restore_ok,
    output map_img_t          restore_img,
    output logic [CNT_W-1:0]  live_cnt
);

    map_img_t          slot_q [SNAP_N];
    logic [SNAP_W-1:0] head_q;
    logic [SNAP_W-1:0] tail_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [SNAP_W-1:0] rs_off;
    logic              rel_ok;

    // Distance of the requested slot from the oldest live one
    assign rs_off     = restore_slot - head_q;
    assign restore_ok = restore && ({1'b0, rs_off} < cnt_q);
    assign take_ok    = take && !restore && (cnt_q < CNT_W'(SNAP_N));
    assign rel_ok     = rel && !restore && (cnt_q != '0);

    assign take_slot   = tail_q;
    assign restore_img = slot_q[restore_slot];
    assign live_cnt    = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
        end else if (restore_ok) begin
            tail_q <= restore_slot + SNAP_W'(1);
            cnt_q  <= {1'b0, rs_off} + CNT_W'(1);
        end else begin
            if (take_ok) begin
                tail_q <= tail_q + SNAP_W'(1);
            end
            if (rel_ok) begin
                head_q <= head_q + SNAP_W'(1);
            end
            cnt_q <= cnt_q + CNT_W'(take_ok) - CNT_W'(rel_ok);
        end
    end

    // Snapshot storage needs no reset: only live slots are ever read back
    always_ff @(posedge clk) begin
        if (take_ok) begin
            slot_q[tail_q] <= cur_img;
        end
    end

endmodule

// File: rtl/rmt_ctrl.sv
module rmt_ctrl
    import rmt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic src_err,
    input  logic restore_ok,
    output logic flushing
);

    ctrl_state_t state_q;
    ctrl_state_t state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: T_DETECT on a source parity error, T_RECOVER on a live restore
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (src_err) begin
                    state_d = ST_FLUSH;
                end
            end
            ST_FLUSH: begin
                if (restore_ok) begin
                    state_d = ST_RUN;
                end
            end
        endcase
    end

    // Outputs
    always_comb begin
        flushing = (state_q == ST_FLUSH);
    end

endmodule

// File: rtl/rmt_alias_table.sv
module rmt_alias_table
    import rmt_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [SRC_N-1:0]              src_vld,
    input  logic [SRC_N-1:0][LREG_W-1:0]  src_lreg,
    output logic [SRC_N-1:0][PID_W-1:0]   src_pid,
    output logic [SRC_N-1:0]              src_par,
    input  logic                          dst_vld,
    input  logic [LREG_W-1:0]             dst_lreg,
    input  logic [PID_W-1:0]              dst_pid,
    input  logic                          dst_par,
    output logic [PID_W-1:0]              old_pid,
    output logic                          old_par,
    input  logic                          snap_take,
    output logic                          snap_take_ok,
    output logic [SNAP_W-1:0]             snap_take_slot,
    input  logic                          snap_release,
    input  logic                          snap_restore,
    input  logic [SNAP_W-1:0]             snap_restore_slot,
    output logic                          flush_req
);

    map_ent_t [SRC_N-1:0] rd_ent;
    map_ent_t             wr_ent;
    map_ent_t             ev_ent;
    map_img_t             cur_img;
    map_img_t             restore_img;
    logic                 wr_en;
    logic                 take_req;
    logic                 restore_ok;
    logic                 src_err;
    logic [CNT_W-1:0]     snap_cnt;

    // Incoming identifier is stored with its own parity bit, never regenerated
    assign wr_ent.pid = dst_pid;
    assign wr_ent.par = dst_par;
    assign wr_en      = dst_vld && !flush_req && !snap_restore;
    assign take_req   = snap_take && !flush_req;

    rmt_map_array u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_lreg  (src_lreg),
        .rd_ent   (rd_ent),
        .wr_en    (wr_en),
        .wr_lreg  (dst_lreg),
        .wr_ent   (wr_ent),
        .ev_ent   (ev_ent),
        .load_en  (restore_ok),
        .load_img (restore_img),
        .cur_img  (cur_img)
    );

    rmt_par_check u_chk (
        .vld     (src_vld),
        .ent     (rd_ent),
        .any_err (src_err)
    );

    rmt_snap_store u_snap (
        .clk          (clk),
        .rst_n        (rst_n),
        .take         (take_req),
        .rel          (snap_release),
        .restore      (snap_restore),
        .restore_slot (snap_restore_slot),
        .cur_img      (cur_img),
        .take_ok      (snap_take_ok),
        .take_slot    (snap_take_slot),
        .restore_ok   (restore_ok),
        .restore_img  (restore_img),
        .live_cnt     (snap_cnt)
    );

    rmt_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_err    (src_err),
        .restore_ok (restore_ok),
        .flushing   (flush_req)
    );

    for (genvar g = 0; g < SRC_N; g++) begin : g_out
        assign src_pid[g] = rd_ent[g].pid;
        assign src_par[g] = rd_ent[g].par;
    end

    assign old_pid = ev_ent.pid;
    assign old_par = ev_ent.par;

endmodule

// File: rtl/rmt_alias_table_chk.sv
module rmt_alias_table_chk
    import rmt_pkg::*;
(
    input logic                         clk,
    input logic                         rst_n,
    input logic [SRC_N-1:0]             src_vld,
    input logic [SRC_N-1:0][PID_W-1:0]  src_pid,
    input logic [SRC_N-1:0]             src_par,
    input logic                         dst_vld,
    input logic [LREG_W-1:0]            dst_lreg,
    input logic [PID_W-1:0]             dst_pid,
    input logic                         dst_par,
    input logic [PID_W-1:0]             old_pid,
    input logic                         old_par,
    input logic                         snap_take,
    input logic                         snap_take_ok,
    input logic                         snap_restore,
    input logic                         restore_ok,
    input logic [CNT_W-1:0]             snap_cnt,
    input logic                         flush_req
);

    logic any_bad;

    always_comb begin
        any_bad = 1'b0;
        for (int g = 0; g < SRC_N; g++) begin
            any_bad = any_bad | (src_vld[g] & (^{src_pid[g], src_par[g]}));
        end
    end

    // R3: a bad valid source read is followed by a flush request
    p_err_flags_flush_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !flush_req && any_bad |=> flush_req);

    // R3: no flush request without a bad valid source read
    p_no_spurious_flush_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !flush_req && !any_bad |=> !flush_req);

    // R4: the request holds until a live restore
    p_flush_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req && !restore_ok |=> flush_req);

    // R4: a live restore ends the request
    p_flush_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req && restore_ok |=> !flush_req);

    // R5: a written mapping is what the next write to that register evicts
    p_evict_follows_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dst_vld && !flush_req && !snap_restore |=>
            (!(dst_vld && dst_lreg == $past(dst_lreg)) ||
             (old_pid == $past(dst_pid) && old_par == $past(dst_par))));

    // R8: acceptance only answers a request
    p_take_ok_needs_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        snap_take_ok |-> snap_take);

    // R9: no take into a full ring, during a flush or beside a restore
    p_take_full_refused_r9: assert property (@(posedge clk) disable iff (!rst_n)
        snap_cnt == CNT_W'(SNAP_N) |-> !snap_take_ok);

    p_take_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_req || snap_restore) |-> !snap_take_ok);

    // R10: live count never exceeds the slot count
    p_cnt_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        snap_cnt <= CNT_W'(SNAP_N));

endmodule

bind rmt_alias_table rmt_alias_table_chk i_rmt_alias_table_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .src_vld      (src_vld),
    .src_pid      (src_pid),
    .src_par      (src_par),
    .dst_vld      (dst_vld),
    .dst_lreg     (dst_lreg),
    .dst_pid      (dst_pid),
    .dst_par      (dst_par),
    .old_pid      (old_pid),
    .old_par      (old_par),
    .snap_take    (snap_take),
    .snap_take_ok (snap_take_ok),
    .snap_restore (snap_restore),
    .restore_ok   (restore_ok),
    .snap_cnt     (snap_cnt),
    .flush_req    (flush_req)
);

// File: tb/test_rmt_alias_table.sv
module test_rmt_alias_table;
    import rmt_pkg::*;

    logic                          clk = 1'b0;
    logic                          rst_n;
    logic [SRC_N-1:0]              src_vld;
    logic [SRC_N-1:0][LREG_W-1:0]  src_lreg;
    logic [SRC_N-1:0][PID_W-1:0]   src_pid;
    logic [SRC_N-1:0]              src_par;
    logic                          dst_vld;
    logic [LREG_W-1:0]             dst_lreg;
    logic [PID_W-1:0]              dst_pid;
    logic                          dst_par;
    logic [PID_W-1:0]              old_pid;
    logic                          old_par;
    logic                          snap_take;
    logic                          snap_take_ok;
    logic [SNAP_W-1:0]             snap_take_slot;
    logic                          snap_release;
    logic                          snap_restore;
    logic [SNAP_W-1:0]             snap_restore_slot;
    logic                          flush_req;

    int n_chk  = 0;
    int n_fail = 0;

    logic [PID_W:0] exp_tab  [LREG_N];
    logic [PID_W:0] snap_img [SNAP_N][LREG_N];

    always #2 clk = ~clk;   // 250 MHz

    rmt_alias_table i_rmt_alias_table (
        .clk               (clk),
        .rst_n             (rst_n),
        .src_vld           (src_vld),
        .src_lreg          (src_lreg),
        .src_pid           (src_pid),
        .src_par           (src_par),
        .dst_vld           (dst_vld),
        .dst_lreg          (dst_lreg),
        .dst_pid           (dst_pid),
        .dst_par           (dst_par),
        .old_pid           (old_pid),
        .old_par           (old_par),
        .snap_take         (snap_take),
        .snap_take_ok      (snap_take_ok),
        .snap_take_slot    (snap_take_slot),
        .snap_release      (snap_release),
        .snap_restore      (snap_restore),
        .snap_restore_slot (snap_restore_slot),
        .flush_req         (flush_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic drive_idle();
        src_vld           = '0;
        src_lreg          = '0;
        dst_vld           = 1'b0;
        dst_lreg          = '0;
        dst_pid           = '0;
        dst_par           = 1'b0;
        snap_take         = 1'b0;
        snap_release      = 1'b0;
        snap_restore      = 1'b0;
        snap_restore_slot = '0;
    endtask

    // Drive a destination write of identifier p with good or bad parity
    task automatic set_write(input int l, input logic [PID_W-1:0] p, input logic good);
        dst_vld  = 1'b1;
        dst_lreg = LREG_W'(l);
        dst_pid  = p;
        dst_par  = good ? ^p : ~^p;
    endtask

    // Read every register through both ports and compare with the model
    task automatic read_all(input string req);
        for (int i = 0; i < LREG_N; i++) begin
            drive_idle();
            src_vld     = '1;
            src_lreg[0] = LREG_W'(i);
            src_lreg[1] = LREG_W'(LREG_N - 1 - i);
            #1;
            check(req, {src_pid[0], src_par[0]}, exp_tab[i]);
            check(req, {src_pid[1], src_par[1]}, exp_tab[LREG_N - 1 - i]);
            @(negedge clk);
        end
        drive_idle();
        check("R3 good parity sweep", flush_req, 0);
    endtask

    task automatic commit_write();
        exp_tab[dst_lreg] = {dst_pid, dst_par};
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        report();
        $finish;
    end

    initial begin
        drive_idle();
        rst_n = 1'b0;
        for (int i = 0; i < LREG_N; i++) exp_tab[i] = {PID_W'(i), ^(PID_W'(i))};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 flush low", flush_req, 0);
        check("R8 first slot", snap_take_slot, 0);
        read_all("R1 R2 reset map");

        // R5 R6: write every register, reading it in the same cycle
        for (int i = 0; i < LREG_N; i++) begin
            drive_idle();
            set_write(i, PID_W'((i * 37 + 11) % 128), 1'b1);
            src_vld     = 2'b01;
            src_lreg[0] = LREG_W'(i);
            #1;
            check("R6 same-cycle read", {src_pid[0], src_par[0]}, exp_tab[i]);
            check("R5 evicted", {old_pid, old_par}, exp_tab[i]);
            @(negedge clk);
            commit_write();
        end
        read_all("R5 written map");

        // R8: fill the ring, one take with a write in the same cycle
        drive_idle();
        snap_take = 1'b1;
        set_write(3, 7'h55, 1'b1);
        #1;
        check("R8 take ok", snap_take_ok, 1);
        check("R8 slot 0", snap_take_slot, 0);
        snap_img[0] = exp_tab;
        @(negedge clk);
        commit_write();
        for (int s = 1; s < SNAP_N; s++) begin
            drive_idle();
            snap_take = 1'b1;
            set_write(3 + s, PID_W'(8'h60 + s), 1'b1);
            #1;
            check("R8 take ok", snap_take_ok, 1);
            check("R8 ring order", snap_take_slot, s);
            snap_img[s] = exp_tab;
            @(negedge clk);
            commit_write();
        end
        drive_idle();
        snap_take = 1'b1;
        #1;
        check("R9 full refused", snap_take_ok, 0);
        @(negedge clk);
        drive_idle();
        set_write(6, 7'h12, 1'b1);
        @(negedge clk);
        commit_write();

        // R11 R7: restore slot 0 with a write in the same cycle
        drive_idle();
        snap_restore      = 1'b1;
        snap_restore_slot = 2'd0;
        set_write(5, 7'h01, 1'b1);
        snap_take = 1'b1;
        #1;
        check("R9 take beside restore", snap_take_ok, 0);
        @(negedge clk);
        exp_tab = snap_img[0];
        drive_idle();
        src_vld = 2'b01; src_lreg[0] = 5'd5;
        #1;
        check("R7 write dropped on restore", {src_pid[0], src_par[0]}, snap_img[0][5]);
        @(negedge clk);
        read_all("R11 restored map");

        // R11: younger slots discarded, next take reuses slot 1
        drive_idle();
        snap_take = 1'b1;
        #1;
        check("R11 slot after restored", snap_take_slot, 1);
        check("R11 take ok", snap_take_ok, 1);
        snap_img[1] = exp_tab;
        @(negedge clk);
        drive_idle();
        set_write(7, 7'h2A, 1'b1);
        @(negedge clk);
        commit_write();
        drive_idle();
        snap_restore = 1'b1; snap_restore_slot = 2'd2;
        @(negedge clk);
        drive_idle();
        src_vld = 2'b10; src_lreg[1] = 5'd7;
        #1;
        check("R11 dead slot ignored", {src_pid[1], src_par[1]}, {7'h2A, ^7'h2A});
        @(negedge clk);

        // R10: release oldest, then restore of the freed slot is ignored
        drive_idle();
        snap_release = 1'b1;
        @(negedge clk);
        drive_idle();
        snap_restore = 1'b1; snap_restore_slot = 2'd0;
        @(negedge clk);
        drive_idle();
        src_vld = 2'b01; src_lreg[0] = 5'd7;
        #1;
        check("R10 released slot dead", {src_pid[0], src_par[0]}, {7'h2A, ^7'h2A});
        @(negedge clk);
        drive_idle();
        snap_restore = 1'b1; snap_restore_slot = 2'd1;
        @(negedge clk);
        exp_tab = snap_img[1];
        drive_idle();
        src_vld = 2'b01; src_lreg[0] = 5'd7;
        #1;
        check("R11 live restore", {src_pid[0], src_par[0]}, snap_img[1][7]);
        @(negedge clk);
        // Empty the ring, then one extra release that must do nothing
        drive_idle(); snap_release = 1'b1; @(negedge clk);
        drive_idle(); snap_release = 1'b1; @(negedge clk);
        for (int k = 0; k < SNAP_N + 1; k++) begin
            drive_idle();
            snap_take = 1'b1;
            #1;
            check("R10 empty release ignored", snap_take_ok, (k < SNAP_N) ? 1 : 0);
            if (k < SNAP_N) check("R8 ring wrap", snap_take_slot, (2 + k) % SNAP_N);
            @(negedge clk);
        end
        for (int k = 0; k < SNAP_N; k++) begin
            drive_idle(); snap_release = 1'b1; @(negedge clk);
        end

        // R3 R4 R7 R9: source parity error and flush
        drive_idle();
        snap_take = 1'b1;
        #1;
        check("R8 slot after wrap", snap_take_slot, 2);
        snap_img[2] = exp_tab;
        @(negedge clk);
        drive_idle();
        set_write(9, 7'h33, 1'b0);
        @(negedge clk);
        check("R5 no check on write", flush_req, 0);
        drive_idle();
        src_vld = 2'b10; src_lreg[0] = 5'd9; src_lreg[1] = 5'd0;
        @(negedge clk);
        check("R3 invalid port unchecked", flush_req, 0);
        drive_idle();
        src_vld = 2'b10; src_lreg[1] = 5'd9;
        #1;
        check("R5 parity kept", {src_pid[1], src_par[1]}, {7'h33, ~^7'h33});
        @(negedge clk);
        check("R3 flush raised", flush_req, 1);
        drive_idle();
        set_write(10, 7'h44, 1'b1);
        snap_take = 1'b1;
        #1;
        check("R9 take during flush", snap_take_ok, 0);
        @(negedge clk);
        check("R4 flush held", flush_req, 1);
        drive_idle();
        snap_restore = 1'b1; snap_restore_slot = 2'd3;
        @(negedge clk);
        check("R4 dead restore keeps flush", flush_req, 1);
        drive_idle();
        snap_restore = 1'b1; snap_restore_slot = 2'd2;
        @(negedge clk);
        check("R4 flush cleared", flush_req, 0);
        exp_tab = snap_img[2];
        read_all("R7 R11 after recovery");

        // R12: bad bit carried through a snapshot
        drive_idle();
        set_write(20, 7'h5A, 1'b0);
        @(negedge clk);
        commit_write();
        drive_idle();
        snap_take = 1'b1;
        #1;
        check("R12 take slot", snap_take_slot, 3);
        snap_img[3] = exp_tab;
        @(negedge clk);
        check("R12 take unchecked", flush_req, 0);
        drive_idle();
        set_write(20, 7'h5A, 1'b1);
        @(negedge clk);
        commit_write();
        drive_idle();
        src_vld = 2'b01; src_lreg[0] = 5'd20;
        @(negedge clk);
        check("R12 good copy passes", flush_req, 0);
        drive_idle();
        snap_restore = 1'b1; snap_restore_slot = 2'd3;
        @(negedge clk);
        check("R12 restore unchecked", flush_req, 0);
        drive_idle();
        src_vld = 2'b01; src_lreg[0] = 5'd20;
        #1;
        check("R12 bad bit restored", {src_pid[0], src_par[0]}, {7'h5A, ~^7'h5A});
        @(negedge clk);
        check("R12 flagged on read", flush_req, 1);
        drive_idle();
        snap_restore = 1'b1; snap_restore_slot = 2'd3;
        @(negedge clk);
        check("R4 cleared again", flush_req, 0);

        drive_idle();
        report();
        $finish;
    end

endmodule